// File: doc/BRIEF.md
# SPD EEPROM Dump Controller

This block is a two-wire serial bus master that copies the first 128 bytes from the presence-detect EEPROM on a memory module. A single pulse on `start_i` launches a fixed sequence with two transactions. The first is a short write: the device address with the write flag, then a single byte of zero, then STOP. It resets the EEPROM's internal location pointer. The second begins with a new START, not a repeated one. It sends the device address with the read flag and then clocks in 128 bytes in a row while the EEPROM advances its pointer by itself.

Both bus lines are open drain. The block never drives a line high. It only asserts an output enable that pulls the line low, and it reads SDA back on a separate input. Each received byte appears on `byte_o` with a one-cycle `byte_vld_o` strobe and its location number on `byte_idx_o`. A clean run ends with a one-cycle `done_o`. If the slave fails to acknowledge any byte the master sends, the block closes the bus with STOP and ends with a one-cycle `err_o` instead. SCL timing comes from a parameter `DIV`, which is the number of clock cycles in each quarter of an SCL period.

Top module: `spd_reader`

## Requirements
- R1: After reset, and whenever the block is idle, both output enables are low, so both lines are released. `busy_o`, `byte_vld_o`, `done_o` and `err_o` are also low in that state.
- R2: The block accepts `start_i` in any idle cycle, including the cycle in which `done_o` or `err_o` pulses, and `busy_o` is high on the next cycle. While `busy_o` is high, `start_i` has no effect on the running sequence.
- R3: The write transaction is START, then the byte 0xA0 (device address 1010000 followed by write flag 0), then the byte 0x00, then STOP. No further byte is written, so the EEPROM pointer ends at location 0.
- R4: The read transaction follows a STOP and opens with a fresh START (never a repeated start). Its first byte is 0xA1 (device address with read flag 1).
- R5: The block reads 128 bytes, MSB first, sampling SDA while SCL is high. Each byte pulses `byte_vld_o` for exactly one cycle, with `byte_idx_o` counting 0 to 127 in order. The bytes are EEPROM locations 0 to 127, whatever the pointer held before the run.
- R6: The master acknowledges (pulls SDA low) bytes 0 to 126. It leaves byte 127 unacknowledged (SDA released), issues STOP, and then pulses `done_o` for one cycle. `done_o` and `err_o` are never high together.
- R7: If the slave leaves SDA high in the acknowledge slot of 0xA0, 0x00 or 0xA1, the block issues STOP and pulses `err_o`. It then returns to idle without producing a data byte and without pulsing `done_o`.
- R8: SDA changes only while SCL is low, except for the START edge (SDA falls, SCL high) and the STOP edge (SDA rises, SCL high). The two output enables never change in the same clock cycle.
- R9: One SCL period is 4·DIV clock cycles: 2·DIV cycles low, then 2·DIV cycles high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to run the dump sequence |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| byte_o | output | 8 | Last received data byte |
| byte_vld_o | output | 1 | One-cycle strobe marking a new byte |
| byte_idx_o | output | 7 | EEPROM location of `byte_o` |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse: 128 bytes read |
| err_o | output | 1 | One-cycle pulse: missing acknowledge |

## Verification
The end of one sequence and the request for the next can land on the same cycle: `done_o` pulses in the first idle cycle, and the block accepts a start in that same cycle. The bench raises `start_i` on exactly the cycle where it sees `done_o` high. It then expects `busy_o` high one cycle later and a second complete, correct dump after that. It also pulses `start_i` in the middle of a run and confirms, through the slave model's START count and the byte total, that the run goes on undisturbed.

// File: rtl/spd_pkg.sv
package spd_pkg;

    // Bus sequencer phases; each phase lasts a whole number of SCL quarters.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_TX    = 3'd2,
        ST_TXACK = 3'd3,
        ST_RX    = 3'd4,
        ST_RXACK = 3'd5,
        ST_STOP  = 3'd6
    } spd_st_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/spd_qtick.sv
// Quarter-period tick generator for SCL timing.
module spd_qtick #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en_i)
            cnt_d = '0;
        else if (cnt_q == LAST)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = en_i && (cnt_q == LAST);

endmodule

// File: rtl/spd_shift.sv
// Shared shifter: serialises outgoing bytes and collects incoming ones.
module spd_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         shift_i,
    input  logic         sin_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i)
            sh_d = load_val_i;
        else if (shift_i)
            sh_d = {sh_q[W-2:0], sin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q;

endmodule

// File: rtl/spd_reader.sv
// Dumps the first NBYTES locations of a single-address-byte SPD EEPROM.
module spd_reader
    import spd_pkg::*;
#(
    parameter int         DIV      = 125,
    parameter int         NBYTES   = 128,
    parameter logic [6:0] DEV_ADDR = 7'b1010000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       sda_i,
    output logic       scl_oe_o,
    output logic       sda_oe_o,
    output logic [7:0] byte_o,
    output logic       byte_vld_o,
    output logic [6:0] byte_idx_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o
);
    localparam int IW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(NBYTES - 1);

    typedef struct packed {
        spd_st_e       st;
        logic [1:0]    qp;        // quarter of the current SCL period
        logic [2:0]    bitn;      // bit within the byte
        logic          rdph;      // 0: pointer write, 1: bulk read
        logic          ptr_sent;  // pointer byte already queued
        logic          nak;       // slave failed to acknowledge
        logic [IW-1:0] idx;
        logic          scl_oe;
        logic          sda_oe;
        logic          vld;
        logic          done;
        logic          err;
    } regs_t;

    regs_t r_d, r_q;

    logic                tick;
    logic [BYTE_W-1:0]   sh_q;
    logic [BYTE_W-1:0]   sh_val;
    logic                sh_load, sh_shift, sh_in;

    spd_qtick #(.DIV(DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (r_q.st != ST_IDLE),
        .tick_o (tick)
    );

    spd_shift #(.W(BYTE_W)) u_sh (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (sh_load),
        .load_val_i (sh_val),
        .shift_i    (sh_shift),
        .sin_i      (sh_in),
        .q_o        (sh_q)
    );

    always_comb begin
        r_d      = r_q;
        r_d.vld  = 1'b0;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        sh_val   = '0;
        sh_in    = 1'b0;

        if (r_q.st == ST_IDLE) begin
            if (start_i) begin
                r_d.st       = ST_START;
                r_d.qp       = 2'd0;
                r_d.bitn     = 3'd0;
                r_d.rdph     = 1'b0;
                r_d.ptr_sent = 1'b0;
                r_d.nak      = 1'b0;
                r_d.idx      = '0;
            end
        end else if (tick) begin
            if (r_q.qp != 2'd3) begin
                r_d.qp = r_q.qp + 2'd1;
                // End of the second quarter: middle of SCL high.
                if (r_q.qp == 2'd2) begin
                    if (r_q.st == ST_TXACK)
                        r_d.nak = sda_i;
                    if (r_q.st == ST_RX) begin
                        sh_shift = 1'b1;
                        sh_in    = sda_i;
                    end
                end
            end else begin
                r_d.qp = 2'd0;
                unique case (r_q.st)
                    ST_START: begin
                        r_d.st   = ST_TX;
                        r_d.bitn = 3'd0;
                        sh_load  = 1'b1;
                        sh_val   = {DEV_ADDR, r_q.rdph};
                    end
                    ST_TX: begin
                        if (r_q.bitn == 3'd7) begin
                            r_d.st = ST_TXACK;
                        end else begin
                            r_d.bitn = r_q.bitn + 3'd1;
                            sh_shift = 1'b1;
                        end
                    end
                    ST_TXACK: begin
                        if (r_q.nak) begin
                            r_d.st = ST_STOP;
                        end else if (!r_q.rdph) begin
                            if (!r_q.ptr_sent) begin
                                r_d.st       = ST_TX;
                                r_d.bitn     = 3'd0;
                                r_d.ptr_sent = 1'b1;
                                sh_load      = 1'b1;
                                sh_val       = '0;
                            end else begin
                                r_d.st = ST_STOP;
                            end
                        end else begin
                            r_d.st   = ST_RX;
                            r_d.bitn = 3'd0;
                        end
                    end
                    ST_RX: begin
                        if (r_q.bitn == 3'd7) begin
                            r_d.st  = ST_RXACK;
                            r_d.vld = 1'b1;
                        end else begin
                            r_d.bitn = r_q.bitn + 3'd1;
                        end
                    end
                    ST_RXACK: begin
                        if (r_q.idx == LAST_IDX) begin
                            r_d.st = ST_STOP;
                        end else begin
                            r_d.idx  = r_q.idx + 1'b1;
                            r_d.st   = ST_RX;
                            r_d.bitn = 3'd0;
                        end
                    end
                    ST_STOP: begin
                        if (r_q.nak) begin
                            r_d.st  = ST_IDLE;
                            r_d.err = 1'b1;
                        end else if (!r_q.rdph) begin
                            r_d.st   = ST_START;
                            r_d.rdph = 1'b1;
                        end else begin
                            r_d.st   = ST_IDLE;
                            r_d.done = 1'b1;
                        end
                    end
                    default: r_d.st = ST_IDLE;
                endcase
            end
        end

        // Line drive for the phase being entered; SDA holds through quarter 0.
        unique case (r_d.st)
            ST_IDLE: begin
                r_d.scl_oe = 1'b0;
                r_d.sda_oe = 1'b0;
            end
            ST_START: begin
                r_d.scl_oe = (r_d.qp == 2'd3);
                r_d.sda_oe = r_d.qp[1];
            end
            default: begin
                r_d.scl_oe = !r_d.qp[1];
                if (r_d.qp == 2'd1) begin
                    unique case (r_d.st)
                        ST_TX:    r_d.sda_oe = !sh_q[BYTE_W-1];
                        ST_RXACK: r_d.sda_oe = (r_q.idx != LAST_IDX);
                        ST_STOP:  r_d.sda_oe = 1'b1;
                        default:  r_d.sda_oe = 1'b0;
                    endcase
                end else if (r_d.st == ST_STOP && r_d.qp == 2'd3) begin
                    r_d.sda_oe = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, qp: 2'd0, bitn: 3'd0, rdph: 1'b0,
                     ptr_sent: 1'b0, nak: 1'b0, idx: '0, scl_oe: 1'b0,
                     sda_oe: 1'b0, vld: 1'b0, done: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_oe_o   = r_q.scl_oe;
    assign sda_oe_o   = r_q.sda_oe;
    assign byte_o     = sh_q;
    assign byte_vld_o = r_q.vld;
    assign byte_idx_o = 7'(r_q.idx);
    assign busy_o     = (r_q.st != ST_IDLE);
    assign done_o     = r_q.done;
    assign err_o      = r_q.err;

    // R8: the two line enables never move in the same cycle.
    a_r8_lines_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(scl_oe_o) && !$stable(sda_oe_o)));

    // R8: SDA moves under a high SCL only while framing START or STOP.
    a_r8_sda_framing_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe_o && !$past(scl_oe_o) && !$stable(sda_oe_o))
        |-> (r_q.st == ST_START || r_q.st == ST_STOP));

    // R5: byte strobe is a single-cycle pulse during a busy sequence.
    a_r5_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |=> !byte_vld_o);

    a_r5_vld_busy: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |-> busy_o);

    // R6: completion and failure are exclusive.
    a_r6_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    // R1: an idle block leaves both lines released.
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!scl_oe_o && !sda_oe_o && !byte_vld_o));

endmodule

// File: tb/spd_reader_test.sv
`timescale 1ns/1ps
module spd_reader_test;
    localparam int DIV = 4;
    localparam int NB  = 128;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n;
    logic       start_i;
    logic       scl_oe, sda_oe;
    logic [7:0] byte_o;
    logic       byte_vld;
    logic [6:0] byte_idx;
    logic       busy, done, err;
    logic       drv;
    logic       scl_line, sda_line;

    assign scl_line = !scl_oe;
    assign sda_line = !sda_oe && !drv;

    spd_reader #(.DIV(DIV), .NBYTES(NB)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sda_i(sda_line),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .byte_o(byte_o),
        .byte_vld_o(byte_vld), .byte_idx_o(byte_idx), .busy_o(busy),
        .done_o(done), .err_o(err)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Stimulus state owned by the main process.
    logic [7:0] mem [NB];
    int         nak_sel = 0;   // 0 none, 1 write address, 2 pointer byte, 3 read address
    bit         scr_req = 1'b0;

    // ---------------- EEPROM slave model ----------------
    int         mode;          // 0 idle 1 addr 2 ptr 3 wdata 4 read
    int         bcnt;
    logic [7:0] sr, rbyte;
    logic [6:0] ptr;
    bit         acked, p_scl, p_sda, stop_seen, scr_prev;
    int         rcount;
    int nstart, nstop, nrep, nextra, nmack, nmnak, badnak;
    logic [7:0] addr_w_last, addr_r_last, ptr_val;

    always @(negedge clk) begin
        logic scl_n, sda_n;
        int which;
        scl_n = scl_line;
        sda_n = sda_line;
        if (!rst_n) begin
            mode = 0; bcnt = 0; drv = 1'b0; ptr = 7'($urandom);
            p_scl = 1'b1; p_sda = 1'b1; stop_seen = 1'b1; scr_prev = scr_req;
            nstart = 0; nstop = 0; nrep = 0; nextra = 0; nmack = 0; nmnak = 0;
            badnak = 0; rcount = 0; acked = 1'b0; sr = '0; rbyte = '0;
            addr_w_last = '0; addr_r_last = '0; ptr_val = 8'hFF;
        end else begin
            if (scr_req != scr_prev) begin
                ptr = 7'($urandom_range(1, NB - 1));
                scr_prev = scr_req;
            end
            if (scl_n && p_scl && p_sda && !sda_n) begin
                if (!stop_seen) nrep++;
                stop_seen = 1'b0;
                nstart++; mode = 1; bcnt = 0; drv = 1'b0;
            end else if (scl_n && p_scl && !p_sda && sda_n) begin
                nstop++; stop_seen = 1'b1; mode = 0; drv = 1'b0;
            end else if (scl_n && !p_scl && mode != 0) begin
                if (bcnt < 8) sr = {sr[6:0], sda_n};
                else if (mode == 4) begin
                    if (sda_n) begin
                        nmnak++;
                        if (rcount != NB) badnak++;
                    end else nmack++;
                    acked = !sda_n;
                end
                bcnt++;
            end else if (!scl_n && p_scl && mode != 0) begin
                if (bcnt == 8) begin
                    if (mode == 4) drv = 1'b0;
                    else begin
                        which = 0;
                        if (mode == 1) begin
                            if (sr[0]) addr_r_last = sr; else addr_w_last = sr;
                            which = (sr[7:1] != 7'h50) ? -1 : (sr[0] ? 3 : 1);
                        end else if (mode == 2) which = 2;
                        else nextra++;
                        acked = (which >= 0) && (which != nak_sel || which == 0);
                        drv = acked;
                    end
                end else if (bcnt == 9) begin
                    drv = 1'b0;
                    bcnt = 0;
                    if (!acked) mode = 0;
                    else if (mode == 1 && sr[0]) begin
                        mode = 4; rcount = 0;
                    end else if (mode == 1) mode = 2;
                    else if (mode == 2) begin
                        ptr = sr[6:0]; ptr_val = sr; mode = 3;
                    end else if (mode == 3) ptr = ptr + 7'd1;
                    if (mode == 4) begin
                        rbyte = mem[ptr]; ptr = ptr + 7'd1; rcount++;
                        drv = !rbyte[7];
                    end
                end else if (mode == 4 && bcnt >= 1 && bcnt <= 7) begin
                    drv = !rbyte[7 - bcnt];
                end
            end
            p_scl = scl_n;
            p_sda = sda_n;
        end
    end

    // ---------------- output monitor ----------------
    int cyc = 0, rise_last = 0, per_last = 0;
    int n_bytes = 0, n_bad = 0, n_perbad = 0;
    logic scl_prev = 1'b1;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (scl_line && !scl_prev) begin
                per_last  = cyc - rise_last;
                rise_last = cyc;
            end
            if (byte_vld) begin
                if (byte_o !== mem[n_bytes % NB] || int'(byte_idx) != n_bytes % NB)
                    n_bad++;
                if (per_last != 4 * DIV) n_perbad++;
                n_bytes++;
            end
        end
        scl_prev = scl_line;
    end

    // ---------------- checks ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fill_mem();
        for (int i = 0; i < NB; i++) mem[i] = 8'($urandom);
    endtask

    // Wait for the end of a sequence; reports which pulse was seen.
    task automatic wait_end(output bit got_done, output bit got_err);
        int t;
        t = 0;
        got_done = 1'b0;
        got_err  = 1'b0;
        do begin
            @(negedge clk);
            t++;
            if (done) got_done = 1'b1;
            if (err)  got_err  = 1'b1;
        end while (!(got_done || got_err) && t < 30000);
        if (t >= 30000) chk(1'b0, "watch-end", t, 0);
    endtask

    function automatic int exp_starts(input int sel);
        return (sel == 1 || sel == 2) ? 1 : 2;
    endfunction

    // One sequence; launched=1 means start was already given.
    task automatic run_seq(input int sel, input bit poke, input bit launched,
                           input bit chain_next);
        int s_start, s_stop, s_rep, s_extra, s_mack, s_mnak, s_bnak;
        int s_bytes, s_bad, s_per;
        bit gd, ge;
        s_start = nstart; s_stop = nstop; s_rep = nrep; s_extra = nextra;
        s_mack = nmack; s_mnak = nmnak; s_bnak = badnak;
        s_bytes = n_bytes; s_bad = n_bad; s_per = n_perbad;
        if (!launched) begin
            nak_sel = sel;
            scr_req = !scr_req;
            @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk(busy == 1'b1, "R2 busy after start", busy, 1);
        end
        if (poke) begin
            repeat (300 + $urandom_range(0, 400)) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait_end(gd, ge);
        if (sel == 0) begin
            chk(gd && !ge, "R6 done pulse", gd, 1);
            chk(n_bytes - s_bytes == NB, "R5 byte count", n_bytes - s_bytes, NB);
            chk(n_bad == s_bad, "R5 byte data/index", n_bad - s_bad, 0);
            chk(n_perbad == s_per, "R9 SCL period", n_perbad - s_per, 0);
            chk(nstart - s_start == 2, "R2 R4 start count", nstart - s_start, 2);
            chk(nstop - s_stop == 2, "R3 R4 stop count", nstop - s_stop, 2);
            chk(nrep == s_rep, "R4 no repeated start", nrep - s_rep, 0);
            chk(addr_w_last == 8'hA0, "R3 write address", addr_w_last, 8'hA0);
            chk(ptr_val == 8'h00, "R3 pointer byte", ptr_val, 0);
            chk(nextra == s_extra, "R3 no extra write", nextra - s_extra, 0);
            chk(addr_r_last == 8'hA1, "R4 read address", addr_r_last, 8'hA1);
            chk(nmack - s_mack == NB - 1, "R6 master acks", nmack - s_mack, NB - 1);
            chk(nmnak - s_mnak == 1 && badnak == s_bnak, "R6 final nack",
                nmnak - s_mnak, 1);
        end else begin
            chk(ge && !gd, "R7 err pulse", ge, 1);
            chk(n_bytes == s_bytes, "R7 no data bytes", n_bytes - s_bytes, 0);
            chk(nstart - s_start == exp_starts(sel), "R7 starts before abort",
                nstart - s_start, exp_starts(sel));
            chk(nstop - s_stop == nstart - s_start, "R7 stop closes bus",
                nstop - s_stop, nstart - s_start);
        end
        if (chain_next) begin
            fill_mem();
            start_i = 1'b1;              // same cycle as done_o
            @(negedge clk);
            start_i = 1'b0;
            chk(busy == 1'b1, "R2 start on done cycle", busy, 1);
        end else begin
            @(negedge clk);
            chk(!busy && !scl_oe && !sda_oe, "R1 R7 idle after run",
                {busy, scl_oe, sda_oe}, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd2718));
        start_i = 1'b0;
        rst_n   = 1'b0;
        fill_mem();
        repeat (5) @(negedge clk);
        // R1: reset state.
        chk(!scl_oe && !sda_oe, "R1 lines released in reset", {scl_oe, sda_oe}, 0);
        chk(!busy && !done && !err && !byte_vld, "R1 flags low in reset",
            {busy, done, err, byte_vld}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !scl_oe && !sda_oe, "R1 idle after reset", {busy, scl_oe, sda_oe}, 0);

        run_seq(0, 1'b1, 1'b0, 1'b0);     // R2: start pulse mid-run ignored
        fill_mem();
        run_seq(0, 1'b0, 1'b0, 1'b1);     // chained into the next
        run_seq(0, 1'b0, 1'b1, 1'b0);
        for (int s = 1; s <= 3; s++) run_seq(s, 1'b0, 1'b0, 1'b0);
        nak_sel = 0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule